// File: doc/BRIEF.md
# Converter Start-Up Output Sequencer

This block sits on the digital output of an audio analog-to-digital converter and hides the samples the converter produces while it settles after being switched on. When the converter enable goes from 0 to 1, the block starts a start-up window. The window lasts a fixed number of sample strobes, and a 2-bit high-pass filter mode field picks that number. While the window is open, and while the converter is off, the sample output is two's complement zero. Once the window closes, incoming samples go to the output unchanged.

The length of the window is taken from the mode field once, at the moment the window opens. The window advances only on sample strobes, and a busy flag marks it. If the enable drops during the window, the window is abandoned and the next rising enable starts a full new one. An active-low power-down input returns the block to its idle state. This input is sampled on the clock edge.

Top module: `adc_init_seq`

## Requirements
- R1: A window opens in the clock cycle after the first edge that samples conv_en = 1 when conv_en was 0 at the edge before. From that cycle busy is 1.
- R2: With hp_mode = 2'b00, busy stays 1 for exactly 3088 sample strobes.
- R3: With hp_mode = 2'b01, busy stays 1 for exactly 1552 sample strobes.
- R4: With hp_mode = 2'b10, busy stays 1 for exactly 784 sample strobes.
- R5: The reserved code hp_mode = 2'b11 gives the same window as 2'b00, which is 3088 strobes.
- R6: hp_mode is read only when a window opens. Changing it while busy = 1 does not change the window length.
- R7: Only edges with smp_stb = 1 and busy = 1 are counted. busy does not fall on an edge without a strobe. A strobe on the edge that opens the window is not counted. busy falls in the cycle after the last counted strobe.
- R8: smp_out is 0 while busy = 1 and while the block is idle. After a window completes with conv_en still 1, smp_out equals smp_in in the same cycle.
- R9: If conv_en is sampled 0 during a window, busy is 0 in the next cycle and smp_out stays 0. The next rising enable starts a full new window.
- R10: shutdown_n = 0 at a clock edge makes busy 0 and smp_out 0 and clears the enable history. If conv_en is held at 1 through reset release, a window opens at the first edge after release.
- R11: After a window completes, conv_en held at 1 never opens a new window, however many strobes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| shutdown_n | input | 1 | Active-low power-down, synchronous |
| conv_en | input | 1 | Converter power-management enable |
| hp_mode | input | 2 | High-pass filter mode code that sets the window length |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_in | input | 16 | Signed sample from the converter |
| smp_out | output | 16 | Gated signed sample |
| busy | output | 1 | High while the start-up window is open |

## Verification
The bench counts the strobes until busy falls for every mode code, including the reserved one. A length table that is off by one, or a wrong mapping for 2'b11, shows up as a wrong count. Gaps between strobes catch a counter that advances on every clock rather than on every strobe. A strobe on the opening edge catches a window that is one strobe short. A mode change in the middle of a window catches a design that reads the live field instead of the latched one. An abort followed by a restart catches a counter that resumes instead of starting over. Holding the enable high through reset, and after completion, catches edge detection that either misses a start or fires a second time.

// File: rtl/adc_init_pkg.sv
package adc_init_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_INIT = 2'b01,
        SEQ_RUN  = 2'b10
    } seq_state_e;

    typedef enum logic [1:0] {
        HPM_SLOW = 2'b00,
        HPM_MID  = 2'b01,
        HPM_FAST = 2'b10,
        HPM_RSVD = 2'b11
    } hpm_e;

    typedef struct packed {
        seq_state_e state;
        hpm_e       mode;
    } seq_ctl_t;

    // Window length for a mode code; the reserved code maps to the slow setting.
    function automatic int unsigned init_len(hpm_e m, int unsigned l_slow,
                                             int unsigned l_mid, int unsigned l_fast);
        case (m)
            HPM_MID:  return l_mid;
            HPM_FAST: return l_fast;
            default:  return l_slow;
        endcase
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_init_edge.sv
module adc_init_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/adc_init_cnt.sv
module adc_init_cnt #(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned LIMIT = 3088
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (step)       cnt <= cnt + 1'b1;
    end

    assign last = (cnt == limit - 1'b1);

    // R7: the strobe count never runs past the longest window
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(LIMIT));
endmodule

// File: rtl/adc_init_gate.sv
module adc_init_gate #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              pass,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    assign dout = pass ? din : '0;
endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq
    import adc_init_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEN_SLOW = 3088,
    parameter int unsigned LEN_MID  = 1552,
    parameter int unsigned LEN_FAST = 784
) (
    input  logic              clk,
    input  logic              shutdown_n,
    input  logic              conv_en,
    input  logic [1:0]        hp_mode,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] smp_in,
    output logic [DATA_W-1:0] smp_out,
    output logic              busy
);
    localparam int unsigned LEN_MAX = max3(LEN_SLOW, LEN_MID, LEN_FAST);
    localparam int unsigned CNT_W   = $clog2(LEN_MAX + 1);

    seq_ctl_t         ctl_q, ctl_d;
    logic             rise;
    logic             cnt_clear, cnt_step, cnt_last;
    logic [CNT_W-1:0] len_q;

    adc_init_edge u_edge (
        .clk   (clk),
        .rst_n (shutdown_n),
        .level (conv_en),
        .rise  (rise)
    );

    // The length comes from the latched mode, so later writes to hp_mode are ignored.
    assign len_q = CNT_W'(init_len(ctl_q.mode, LEN_SLOW, LEN_MID, LEN_FAST));

    adc_init_cnt #(.CNT_W(CNT_W), .LIMIT(LEN_MAX)) u_cnt (
        .clk   (clk),
        .rst_n (shutdown_n),
        .clear (cnt_clear),
        .step  (cnt_step),
        .limit (len_q),
        .last  (cnt_last)
    );

    always_comb begin
        ctl_d     = ctl_q;
        cnt_clear = 1'b0;
        cnt_step  = 1'b0;
        case (ctl_q.state)
            SEQ_IDLE: begin
                if (rise) begin
                    ctl_d.state = SEQ_INIT;
                    ctl_d.mode  = hpm_e'(hp_mode);
                    cnt_clear   = 1'b1;
                end
            end
            SEQ_INIT: begin
                if (!conv_en) begin
                    ctl_d.state = SEQ_IDLE;
                    cnt_clear   = 1'b1;
                end else if (smp_stb) begin
                    if (cnt_last) begin
                        ctl_d.state = SEQ_RUN;
                        cnt_clear   = 1'b1;
                    end else begin
                        cnt_step = 1'b1;
                    end
                end
            end
            SEQ_RUN: begin
                if (!conv_en) ctl_d.state = SEQ_IDLE;
            end
            default: begin
                ctl_d.state = SEQ_IDLE;
                cnt_clear   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!shutdown_n) ctl_q <= '{state: SEQ_IDLE, mode: HPM_SLOW};
        else             ctl_q <= ctl_d;
    end

    assign busy = (ctl_q.state == SEQ_INIT);

    adc_init_gate #(.DATA_W(DATA_W)) u_gate (
        .pass (ctl_q.state == SEQ_RUN),
        .din  (smp_in),
        .dout (smp_out)
    );

    // R1: a rising enable opens the window on the next cycle
    p_start_r1: assert property (@(posedge clk) disable iff (!shutdown_n)
        $rose(conv_en) |=> busy);
    // R8: output is forced to zero while the window is open
    p_zero_busy_r8: assert property (@(posedge clk) disable iff (!shutdown_n)
        busy |-> (smp_out == '0));
    // R9: a dropped enable closes the window with the output at zero
    p_abort_r9: assert property (@(posedge clk) disable iff (!shutdown_n)
        !conv_en |=> (!busy && smp_out == '0));
    // R7: without a strobe the window stays open
    p_hold_r7: assert property (@(posedge clk) disable iff (!shutdown_n)
        (busy && conv_en && !smp_stb) |=> busy);
    // R6: the latched mode does not move inside a window
    p_mode_hold_r6: assert property (@(posedge clk) disable iff (!shutdown_n)
        busy |=> (!busy || $stable(ctl_q.mode)));
endmodule

// File: tb/adc_init_seq_test.sv
module adc_init_seq_test;
    logic        clk = 1'b0;
    logic        shutdown_n = 1'b0;
    logic        conv_en = 1'b0;
    logic [1:0]  hp_mode = 2'b00;
    logic        smp_stb = 1'b0;
    logic [15:0] smp_in = 16'h0000;
    logic [15:0] smp_out;
    logic        busy;

    int checks = 0;
    int fails = 0;
    int n;

    localparam int NVEC = 5;
    localparam int VEC_MODE[NVEC] = '{0, 1, 2, 3, 2};
    localparam int VEC_GAP[NVEC]  = '{0, 1, 0, 0, 2};
    localparam int VEC_LEN[NVEC]  = '{3088, 1552, 784, 3088, 784};

    always #5 clk = ~clk;

    adc_init_seq uut (
        .clk(clk), .shutdown_n(shutdown_n), .conv_en(conv_en), .hp_mode(hp_mode),
        .smp_stb(smp_stb), .smp_in(smp_in), .smp_out(smp_out), .busy(busy)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobes with 'gap' idle cycles between them until busy falls; returns strobe count.
    task automatic count_strobes(input int gap, output int cnt);
        cnt = 0;
        while (cnt < 5000) begin
            smp_stb = 1'b1;
            smp_in  = 16'h1234 + 16'(cnt);
            tick();
            smp_stb = 1'b0;
            cnt++;
            if (!busy) break;
            if (smp_out != 16'h0) chk(1'b0, "R8 zero while busy", int'(smp_out), 0);
            for (int g = 0; g < gap; g++) begin
                tick();
                if (!busy) begin
                    chk(1'b0, "R7 busy fell without strobe", 0, 1);
                    cnt = 9999;
                    return;
                end
            end
        end
    endtask

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R10 reset state
        smp_in = 16'h7ABC;
        tick(); tick();
        chk(busy == 1'b0, "R10 busy in reset", int'(busy), 0);
        chk(smp_out == 16'h0, "R10 out in reset", int'(smp_out), 0);
        shutdown_n = 1'b1;
        tick();
        chk(busy == 1'b0 && smp_out == 16'h0, "R8 idle output zero", int'(smp_out), 0);

        // Table of mode / strobe gap / expected window (R2 R3 R4 R5)
        for (int v = 0; v < NVEC; v++) begin
            hp_mode = 2'(VEC_MODE[v]);
            conv_en = 1'b1;
            tick();
            chk(busy == 1'b1, "R1 window opens", int'(busy), 1);
            count_strobes(VEC_GAP[v], n);
            chk(n == VEC_LEN[v], $sformatf("R2/R3/R4/R5 mode %0d length", VEC_MODE[v]), n, VEC_LEN[v]);
            smp_in = 16'h8001;
            #1;
            chk(smp_out == 16'h8001, "R8 pass-through after window", int'(smp_out), 32769);
            conv_en = 1'b0;
            tick();
            chk(busy == 1'b0 && smp_out == 16'h0, "R8 off output zero", int'(smp_out), 0);
        end

        // R7 strobe on the opening edge is not counted
        hp_mode = 2'b10;
        conv_en = 1'b1;
        smp_stb = 1'b1;
        tick();
        smp_stb = 1'b0;
        count_strobes(0, n);
        chk(n == 784, "R7 opening strobe not counted", n, 784);

        // R11 no restart with enable held
        for (int i = 0; i < 900; i++) begin
            smp_stb = 1'b1;
            tick();
            if (busy) begin
                chk(1'b0, "R11 restart with enable held", 1, 0);
                break;
            end
        end
        smp_stb = 1'b0;
        chk(busy == 1'b0, "R11 stays done", int'(busy), 0);
        conv_en = 1'b0;
        tick();

        // R6 mode change mid-window ignored
        hp_mode = 2'b10;
        conv_en = 1'b1;
        tick();
        for (int i = 0; i < 10; i++) begin
            smp_stb = 1'b1; tick();
        end
        smp_stb = 1'b0;
        hp_mode = 2'b00;
        count_strobes(0, n);
        chk(n + 10 == 784, "R6 latched mode length", n + 10, 784);
        conv_en = 1'b0;
        tick();

        // R9 abort and full restart
        hp_mode = 2'b01;
        conv_en = 1'b1;
        tick();
        for (int i = 0; i < 100; i++) begin
            smp_stb = 1'b1; tick();
        end
        smp_stb = 1'b0;
        conv_en = 1'b0;
        smp_in = 16'h5555;
        tick();
        chk(busy == 1'b0, "R9 abort clears busy", int'(busy), 0);
        chk(smp_out == 16'h0, "R9 abort output zero", int'(smp_out), 0);
        conv_en = 1'b1;
        tick();
        chk(busy == 1'b1, "R9 restart opens", int'(busy), 1);
        count_strobes(0, n);
        chk(n == 1552, "R9 restart full length", n, 1552);

        // R10 reset mid-window with enable held high
        conv_en = 1'b0;
        tick();
        hp_mode = 2'b10;
        conv_en = 1'b1;
        tick();
        for (int i = 0; i < 20; i++) begin
            smp_stb = 1'b1; tick();
        end
        smp_stb = 1'b0;
        shutdown_n = 1'b0;
        tick();
        chk(busy == 1'b0 && smp_out == 16'h0, "R10 reset mid-window", int'(busy), 0);
        shutdown_n = 1'b1;
        tick();
        chk(busy == 1'b1, "R10 window after release", int'(busy), 1);
        count_strobes(0, n);
        chk(n == 784, "R10 full window after reset", n, 784);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule